// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is one compare/capture channel that sits beside a free-running timer counter. The counter, its prescaler and the bus decode are outside the block. The block receives the counter value, a count-enable qualifier and the count events of a cascaded neighbour counter. A 4-bit role field sets what the channel does. In compare roles it drives an output pin. The pin starts at a programmed level, and each match between the counter and the channel register can clear, set or toggle it. In capture roles it copies the counter into the channel register. The trigger is either an edge of a synchronized input pin or a count event of the cascaded counter.

A sticky status flag records every match and capture. Software clears the flag by writing a one. An interrupt request is raised while both the flag and its enable are set. A buffer-mode input stops all compare and capture activity, so the register then only holds what software writes into it.

Top module: `tmr_chan`

## Requirements
- R1: After reset the role field is 0000, and pinOut, pinOe, regVal, flag and irq are all 0.
- R2: Writing the role field with bit 3 = 0 loads pinOut with bit 2 at that clock edge. pinOe is 1 in a compare role unless bits 1:0 are 00. Codes with bit 3 = 1 leave pinOut unchanged.
- R3: In a compare role, a match is a cycle with cntEn = 1 and cntVal equal to regVal. Bits 1:0 then select the pin action at that edge: 01 drives 0, 10 drives 1, 11 toggles, and 00 leaves the pin unchanged. Without cntEn there is no match.
- R4: Role 10xx captures on the synchronized pin. Bits 1:0 select the edge: 00 rising, 01 falling, 1x both. When pinIn changes before clock edge n, regVal takes the cntVal present at edge n+2, and the opposite edge in a single-edge mode does nothing.
- R5: Role 11xx loads cntVal into regVal at every clock edge where cascTick = 1.
- R6: While cascFastClk = 1, role 11xx captures nothing.
- R7: While bufMode = 1 there is no capture, no pin action on a match, no flag set, and pinOe is 0. regVal still accepts software writes.
- R8: Every match in a compare role and every capture sets flag. The flag holds until a cycle with flagClr = 1, and a set in the same cycle wins over the clear.
- R9: irq equals flag AND irqEn.
- R10: regWe loads regData into regVal. A capture in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Write strobe for the role field |
| ctrlData | input | 4 | New role field value |
| regWe | input | 1 | Software write strobe for the channel register |
| regData | input | W | Software write data |
| flagClr | input | 1 | Write-one-to-clear for the status flag |
| irqEn | input | 1 | Interrupt enable |
| bufMode | input | 1 | Buffer-mode override |
| cntVal | input | W | Current timer counter value |
| cntEn | input | 1 | Counter holds a fresh value this cycle |
| pinIn | input | 1 | Asynchronous capture pin |
| cascTick | input | 1 | Count event of the cascaded counter |
| cascFastClk | input | 1 | Cascaded counter runs on the undivided clock |
| pinOut | output | 1 | Compare output level |
| pinOe | output | 1 | Compare output enable |
| regVal | output | W | Channel register |
| flag | output | 1 | Sticky match/capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that cntEn is high for only one cycle per counter value, so that one counter value causes at most one match action. The bench therefore raises cntEn for a single cycle at each match. The assertions also assume that the cascade inputs and flagClr are already synchronous to clk. The bench drives every input one time unit after a rising edge and holds pinIn stable long enough that the two-flop synchronizer never sees a pulse shorter than one cycle.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;
  // Strobes from the control half to the datapath half, valid for one cycle.
  typedef struct packed {
    logic loadInit;  // role write with a compare code
    logic initLvl;   // level to load with loadInit
    logic setPin;
    logic clrPin;
    logic togPin;
    logic capture;   // copy counter into channel register
    logic setFlag;
  } chanStrb_t;

  typedef enum logic [1:0] {
    ROLE_CMP    = 2'd0,
    ROLE_PINCAP = 2'd1,
    ROLE_CASCAP = 2'd2
  } chanRole_t;
endpackage

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl
  import tmr_chan_pkg::*;
#(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctrlWe,
  input  logic [3:0]   ctrlData,
  input  logic         bufMode,
  input  logic         pinIn,
  input  logic         cascTick,
  input  logic         cascFastClk,
  input  logic         cntEn,
  input  logic [W-1:0] cntVal,
  input  logic [W-1:0] regVal,
  output chanStrb_t    strb,
  output logic         pinOe
);
  localparam int PIPE = SYNC + 1;

  logic [3:0]      modeReg;
  logic [PIPE-1:0] syncPipe;
  logic            sNew, sOld, riseEv, fallEv, pinEdge, matchHit;
  chanRole_t       role;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= 4'b0000;
      syncPipe <= '0;
    end else begin
      if (ctrlWe) modeReg <= ctrlData;
      syncPipe <= {syncPipe[PIPE-2:0], pinIn};
    end
  end

  assign sNew   = syncPipe[SYNC-1];
  assign sOld   = syncPipe[SYNC];
  assign riseEv = sNew & ~sOld;
  assign fallEv = ~sNew & sOld;

  always_comb begin
    if (!modeReg[3])      role = ROLE_CMP;
    else if (!modeReg[2]) role = ROLE_PINCAP;
    else                  role = ROLE_CASCAP;
  end

  always_comb begin
    unique case (modeReg[1:0])
      2'b00:   pinEdge = riseEv;
      2'b01:   pinEdge = fallEv;
      default: pinEdge = riseEv | fallEv;
    endcase
  end

  assign matchHit = cntEn && (cntVal == regVal);

  always_comb begin
    strb          = '0;
    strb.loadInit = ctrlWe && !ctrlData[3];
    strb.initLvl  = ctrlData[2];
    if (!bufMode) begin
      unique case (role)
        ROLE_CMP: begin
          if (matchHit) begin
            strb.setFlag = 1'b1;
            strb.clrPin  = (modeReg[1:0] == 2'b01);
            strb.setPin  = (modeReg[1:0] == 2'b10);
            strb.togPin  = (modeReg[1:0] == 2'b11);
          end
        end
        ROLE_PINCAP: strb.capture = pinEdge;
        ROLE_CASCAP: strb.capture = cascTick && !cascFastClk;
        default: ;
      endcase
      if (strb.capture) strb.setFlag = 1'b1;
    end
  end

  assign pinOe = (role == ROLE_CMP) && (modeReg[1:0] != 2'b00) && !bufMode;

  AST_BUF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    bufMode |-> !strb.capture && !strb.setFlag && !pinOe) else $error("bufMode activity"); // R7

  AST_FAST_NO_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[3:2] == 2'b11 && cascFastClk) |-> !strb.capture) else $error("fast-clock capture"); // R6

  AST_PIN_CAP_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && modeReg[3:2] == 2'b10) |-> (sNew != sOld)) else $error("capture without edge"); // R4

  AST_MATCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setPin || strb.clrPin || strb.togPin) |-> cntEn) else $error("pin action without cntEn"); // R3
endmodule

// File: rtl/tmr_chan_dp.sv
module tmr_chan_dp
  import tmr_chan_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  chanStrb_t    strb,
  input  logic         regWe,
  input  logic [W-1:0] regData,
  input  logic         flagClr,
  input  logic         irqEn,
  input  logic [W-1:0] cntVal,
  output logic [W-1:0] regVal,
  output logic         pinOut,
  output logic         flag,
  output logic         irq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regVal <= '0;
      pinOut <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (strb.capture)  regVal <= cntVal;
      else if (regWe)    regVal <= regData;

      if (strb.loadInit)    pinOut <= strb.initLvl;
      else if (strb.setPin) pinOut <= 1'b1;
      else if (strb.clrPin) pinOut <= 1'b0;
      else if (strb.togPin) pinOut <= ~pinOut;

      if (strb.setFlag)  flag <= 1'b1;
      else if (flagClr)  flag <= 1'b0;
    end
  end

  assign irq = flag & irqEn;

  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> regVal == $past(cntVal)) else $error("capture value"); // R5

  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.togPin && !strb.loadInit) |=> pinOut != $past(pinOut)) else $error("toggle"); // R3

  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadInit |=> pinOut == $past(strb.initLvl)) else $error("initial level"); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !flagClr) |=> flag) else $error("flag dropped"); // R8

  AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !strb.capture) |=> regVal == $past(regData)) else $error("software write"); // R10
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctrlWe,
  input  logic [3:0]   ctrlData,
  input  logic         regWe,
  input  logic [W-1:0] regData,
  input  logic         flagClr,
  input  logic         irqEn,
  input  logic         bufMode,
  input  logic [W-1:0] cntVal,
  input  logic         cntEn,
  input  logic         pinIn,
  input  logic         cascTick,
  input  logic         cascFastClk,
  output logic         pinOut,
  output logic         pinOe,
  output logic [W-1:0] regVal,
  output logic         flag,
  output logic         irq
);
  chanStrb_t strb;

  tmr_chan_ctrl #(.W(W), .SYNC(SYNC)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .bufMode(bufMode), .pinIn(pinIn), .cascTick(cascTick),
    .cascFastClk(cascFastClk), .cntEn(cntEn), .cntVal(cntVal),
    .regVal(regVal), .strb(strb), .pinOe(pinOe)
  );

  tmr_chan_dp #(.W(W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWe(regWe), .regData(regData),
    .flagClr(flagClr), .irqEn(irqEn), .cntVal(cntVal), .regVal(regVal),
    .pinOut(pinOut), .flag(flag), .irq(irq)
  );

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flag && irqEn) else $error("irq without flag"); // R9
endmodule

// File: tb/tmr_chan_test.sv
module tmr_chan_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         ctrlWe = 0, regWe = 0, flagClr = 0, irqEn = 0, bufMode = 0;
  logic [3:0]   ctrlData = '0;
  logic [W-1:0] regData = '0, cntVal = '0;
  logic         cntEn = 0, pinIn = 0, cascTick = 0, cascFastClk = 0;
  logic         pinOut, pinOe, flag, irq;
  logic [W-1:0] regVal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_chan #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlData(ctrlData),
    .regWe(regWe), .regData(regData), .flagClr(flagClr), .irqEn(irqEn),
    .bufMode(bufMode), .cntVal(cntVal), .cntEn(cntEn), .pinIn(pinIn),
    .cascTick(cascTick), .cascFastClk(cascFastClk), .pinOut(pinOut),
    .pinOe(pinOe), .regVal(regVal), .flag(flag), .irq(irq)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic writeCtrl(input logic [3:0] code);
    ctrlData = code; ctrlWe = 1; tick(); ctrlWe = 0;
  endtask

  task automatic clearFlag();
    flagClr = 1; tick(); flagClr = 0;
  endtask

  task automatic matchOnce(input logic [W-1:0] v);
    cntVal = v; cntEn = 1; tick(); cntEn = 0;
  endtask

  task automatic t_reset();
    tick(2);
    rstN = 1; tick();
    chk("R1", "pinOut", pinOut, 0);
    chk("R1", "pinOe", pinOe, 0);
    chk("R1", "regVal", regVal, 0);
    chk("R1", "flag", flag, 0);
    chk("R1", "irq", irq, 0);
  endtask

  task automatic t_compare_init();
    writeCtrl(4'b0100);
    chk("R2", "init1 disabled pinOut", pinOut, 1);
    chk("R2", "disabled pinOe", pinOe, 0);
    writeCtrl(4'b0001);
    chk("R2", "init0 pinOut", pinOut, 0);
    chk("R2", "enabled pinOe", pinOe, 1);
    writeCtrl(4'b0110);
    chk("R2", "init1 pinOut", pinOut, 1);
    writeCtrl(4'b1100);
    chk("R2", "capture code keeps pin", pinOut, 1);
    chk("R2", "capture code pinOe", pinOe, 0);
  endtask

  task automatic t_match();
    regData = 16'h0040; regWe = 1; tick(); regWe = 0;
    chk("R10", "software write", regVal, 16'h0040);
    writeCtrl(4'b0011);
    cntVal = 16'h0040; cntEn = 0; tick();
    chk("R3", "no match without cntEn", pinOut, 0);
    chk("R8", "no flag without cntEn", flag, 0);
    matchOnce(16'h0040);
    chk("R3", "toggle 0->1", pinOut, 1);
    chk("R8", "flag on match", flag, 1);
    matchOnce(16'h0041);
    chk("R3", "mismatch keeps pin", pinOut, 1);
    matchOnce(16'h0040);
    chk("R3", "toggle 1->0", pinOut, 0);
    writeCtrl(4'b0101);
    chk("R2", "init1 for clear test", pinOut, 1);
    matchOnce(16'h0040);
    chk("R3", "clear on match", pinOut, 0);
    writeCtrl(4'b0010);
    chk("R2", "init0 for set test", pinOut, 0);
    matchOnce(16'h0040);
    chk("R3", "set on match", pinOut, 1);
    writeCtrl(4'b0100);
    clearFlag();
    chk("R8", "flag cleared", flag, 0);
    matchOnce(16'h0040);
    chk("R3", "disabled code keeps pin", pinOut, 1);
    chk("R8", "flag on match with output disabled", flag, 1);
    clearFlag();
  endtask

  task automatic t_flag_irq();
    writeCtrl(4'b0011);
    irqEn = 0;
    matchOnce(16'h0040);
    chk("R9", "irq masked", irq, 0);
    irqEn = 1; #1;
    chk("R9", "irq enabled", irq, 1);
    flagClr = 1; matchOnce(16'h0040); flagClr = 0;
    chk("R8", "set wins over clear", flag, 1);
    tick(2);
    chk("R8", "flag sticky", flag, 1);
    clearFlag();
    chk("R8", "flag cleared", flag, 0);
    chk("R9", "irq follows flag", irq, 0);
    irqEn = 0;
  endtask

  task automatic t_pin_capture();
    writeCtrl(4'b1000);
    tick(3);
    cntVal = 16'h1111;
    pinIn = 1; tick(2);
    chk("R4", "no capture before sync", regVal, 16'h0040);
    tick();
    chk("R4", "rising capture", regVal, 16'h1111);
    chk("R8", "flag on capture", flag, 1);
    clearFlag();
    cntVal = 16'h2222; pinIn = 0; tick(4);
    chk("R4", "falling ignored in rising mode", regVal, 16'h1111);
    chk("R4", "no flag on ignored edge", flag, 0);
    writeCtrl(4'b1001);
    cntVal = 16'h3333; pinIn = 1; tick(4);
    chk("R4", "rising ignored in falling mode", regVal, 16'h1111);
    pinIn = 0; tick(3);
    chk("R4", "falling capture", regVal, 16'h3333);
    writeCtrl(4'b1010);
    cntVal = 16'h4444; pinIn = 1; tick(3);
    chk("R4", "both-edge rising", regVal, 16'h4444);
    cntVal = 16'h5555; pinIn = 0; tick(3);
    chk("R4", "both-edge falling", regVal, 16'h5555);
    clearFlag();
  endtask

  task automatic t_cascade();
    writeCtrl(4'b1100);
    cntVal = 16'h0077; cascTick = 1; tick(); cascTick = 0;
    chk("R5", "cascade capture", regVal, 16'h0077);
    chk("R8", "flag on cascade capture", flag, 1);
    cntVal = 16'h0088; tick();
    chk("R5", "no capture without tick", regVal, 16'h0077);
    clearFlag();
    cascFastClk = 1; cntVal = 16'h0099; cascTick = 1; tick(); cascTick = 0;
    chk("R6", "fast clock blocks capture", regVal, 16'h0077);
    chk("R6", "fast clock no flag", flag, 0);
    cascFastClk = 0;
  endtask

  task automatic t_buffer();
    bufMode = 1;
    writeCtrl(4'b0011);
    chk("R7", "pinOe off in buffer mode", pinOe, 0);
    regData = 16'h0123; regWe = 1; tick(); regWe = 0;
    chk("R7", "buffer write", regVal, 16'h0123);
    matchOnce(16'h0123);
    chk("R7", "no pin action", pinOut, 0);
    chk("R7", "no flag on match", flag, 0);
    writeCtrl(4'b1100);
    cntVal = 16'h0456; cascTick = 1; tick(); cascTick = 0;
    chk("R7", "no capture", regVal, 16'h0123);
    chk("R7", "no flag on capture", flag, 0);
    bufMode = 0;
  endtask

  task automatic t_priority();
    writeCtrl(4'b1100);
    regData = 16'hAAAA; regWe = 1; cntVal = 16'hBBBB; cascTick = 1; tick();
    regWe = 0; cascTick = 0;
    chk("R10", "capture beats write", regVal, 16'hBBBB);
    clearFlag();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    #1;
    t_reset();
    t_compare_init();
    t_match();
    t_flag_irq();
    t_pin_capture();
    t_cascade();
    t_buffer();
    t_priority();
    finishRun();
  end
endmodule